// File: doc/BRIEF.md
# Programmable Watchdog Timer

This block watches for a stalled processor. Software writes one byte of configuration into a watchdog register. The byte holds a steering bit, a multiplier and a resolution code. After each restart the block counts pulses of a 16 Hz timebase. If software does not touch the watchdog register before the programmed number of pulses has passed, the block sets a watchdog flag. It can also raise an interrupt request.

Software restarts the count by reading or writing the watchdog register. It clears the flag either by reading the flags register or by touching the watchdog register. A multiplier of zero keeps the timer idle, and power-up leaves it in that state. After a timeout the count stops and waits for the next access to the watchdog register.

Top module: `wdog_timer`

## Requirements
- R1: After reset the watchdog register reads 00h, the flag is 0, the interrupt request is 0 and the timer is idle.
- R2: The watchdog register (address 7h) holds the steering bit in bit 7, the multiplier in bits 6:2 and the resolution code in bits 1:0. The timeout in ticks is the multiplier times a unit of 1, 4, 16 or 64 ticks, for resolution codes 00, 01, 10 and 11 respectively.
- R3: With no access in between, the flag rises on the clock edge that samples the timeout-th tick after the last restart, and at no other time.
- R4: Any read or write of address 7h restarts the count from zero. A tick sampled on the same edge as such an access is not counted.
- R5: While the multiplier is 0 (for example after writing 00h or 03h), the flag never rises.
- R6: Any read or write of address 7h clears the flag on that edge. Once set, the flag otherwise stays at 1 until a clearing access.
- R7: A read of the flags register (address 0h) returns the flag in bit 7 and zeros elsewhere, and clears the flag. If a timeout happens on the same edge, the flag stays set and the read returns the value it had before.
- R8: After a timeout the count halts. Clearing the flag through address 0h does not start a new timeout until address 7h is accessed.
- R9: When the steering bit is 0, the interrupt request equals the flag. When it is 1, the interrupt request stays at 0 while the flag still works.
- R10: Read data appears on the edge that samples the read strobe and holds until the next read. Address 7h returns the configuration; addresses other than 0h and 7h return 00h.
- R11: Writes to any address other than 7h change neither the configuration nor the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low power-up reset |
| tick_16hz | input | 1 | One-cycle pulse of the 16 Hz timebase |
| acc_en | input | 1 | Register access strobe, one cycle per access |
| acc_wr | input | 1 | 1 for write, 0 for read |
| acc_addr | input | 4 | Register address |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Registered read data |
| wdog_flag | output | 1 | Watchdog flag |
| irq_req | output | 1 | Interrupt request, active high |

## Verification
The flag, the read data and the interrupt request all change on the same clock edge that samples the deciding strobe or tick, so each result is due exactly one edge after its stimulus. The bench drives inputs on falling edges. A reference model steps once on every rising edge, and the bench compares all three outputs to it at the next falling edge. Directed checks count ticks until the flag rises and compare that count to multiplier times unit. They also place an access on the same edge as a tick to pin down which event takes precedence.

// File: rtl/wdog_pkg.sv
// Package: shared types and constants of the watchdog timer.
// Assumes an 8-bit configuration byte split into steer / multiplier / resolution.
package wdog_pkg;

    localparam int MULT_W   = 5;   // multiplier field width
    localparam int RES_W    = 2;   // resolution code width
    localparam int RES_STEP = 2;   // log2 of the ratio between adjacent units
    localparam int CNT_W    = MULT_W + RES_STEP * ((1 << RES_W) - 1);
    localparam int DATA_W   = 1 + MULT_W + RES_W;
    localparam int FLAG_BIT = DATA_W - 1;

    typedef struct packed {
        logic              steer;
        logic [MULT_W-1:0] mult;
        logic [RES_W-1:0]  res;
    } wdog_cfg_t;

    // Timeout length in ticks: multiplier scaled by 4**res.
    function automatic logic [CNT_W-1:0] period_ticks(input wdog_cfg_t c);
        return CNT_W'(c.mult) << (RES_STEP * int'(c.res));
    endfunction

endpackage

// File: rtl/wdog_bus_decode.sv
// Module: turns one register access into the strobes the watchdog needs.
// Assumes acc_en is a single-cycle strobe per access.
module wdog_bus_decode #(
    parameter int              ADDR_W     = 4,
    parameter logic [ADDR_W-1:0] WDOG_ADDR  = 7,
    parameter logic [ADDR_W-1:0] FLAGS_ADDR = 0
) (
    input  logic              acc_en,
    input  logic              acc_wr,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic              wr_cfg,
    output logic              touch_cfg,
    output logic              rd_flags,
    output logic              rd_any
);

    // Purpose: decode address and direction into access strobes.
    always_comb begin
        touch_cfg = acc_en && (acc_addr == WDOG_ADDR);
        wr_cfg    = touch_cfg && acc_wr;
        rd_flags  = acc_en && !acc_wr && (acc_addr == FLAGS_ADDR);
        rd_any    = acc_en && !acc_wr;
    end

endmodule

// File: rtl/wdog_cfg_reg.sv
// Module: holds the watchdog configuration byte.
// Assumes reset is the power-up event, which leaves the timer disabled.
module wdog_cfg_reg
    import wdog_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_cfg,
    input  logic [DATA_W-1:0] wdata,
    output wdog_cfg_t         cfg_q
);

    // Purpose: load the configuration on a write, clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_q <= '0;
        else if (wr_cfg) cfg_q <= wdog_cfg_t'(wdata);
    end

endmodule

// File: rtl/wdog_counter.sv
// Module: counts timebase ticks since the last restart and pulses on expiry.
// Assumes period is constant between restarts (it changes only on a write,
// which also restarts). A zero period never expires. A restart outranks a tick.
module wdog_counter #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             tick,
    input  logic [CNT_W-1:0] period,
    output logic             expire
);

    logic [CNT_W-1:0] cnt_q;
    logic             run_q;
    logic [CNT_W-1:0] cnt_inc;
    logic             counting;

    // Purpose: next count value and whether this tick is counted.
    always_comb begin
        cnt_inc  = cnt_q + CNT_W'(1);
        counting = tick && run_q && !restart && (period != '0);
        expire   = counting && (cnt_inc == period);
    end

    // Purpose: restart, advance, or halt the tick count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (restart) begin
            cnt_q <= '0;
            run_q <= 1'b1;
        end else if (expire) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (counting) begin
            cnt_q <= cnt_inc;
        end
    end

endmodule

// File: rtl/wdog_flag.sv
// Module: watchdog flag and steered interrupt request.
// Assumes expiry and a watchdog-register access never coincide (counter rule).
module wdog_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic touch_cfg,
    input  logic rd_flags,
    input  logic steer,
    output logic flag_q,
    output logic irq
);

    // Purpose: set on expiry (wins), clear on any clearing access.
    always_ff @(posedge clk) begin
        if (!rst_n)                      flag_q <= 1'b0;
        else if (expire)                 flag_q <= 1'b1;
        else if (touch_cfg || rd_flags)  flag_q <= 1'b0;
    end

    // Purpose: route the flag to the interrupt only when steer is 0.
    always_comb irq = flag_q && !steer;

endmodule

// File: rtl/wdog_timer.sv
// Module: top of the programmable watchdog timer.
// Assumes tick_16hz is a one-cycle pulse synchronous to clk and that
// rst_n is asserted at power-up.
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int                ADDR_W     = 4,
    parameter logic [ADDR_W-1:0] WDOG_ADDR  = 7,
    parameter logic [ADDR_W-1:0] FLAGS_ADDR = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_16hz,
    input  logic              acc_en,
    input  logic              acc_wr,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [7:0]        acc_wdata,
    output logic [7:0]        acc_rdata,
    output logic              wdog_flag,
    output logic              irq_req
);

    logic       wr_cfg, touch_cfg, rd_flags, rd_any;
    wdog_cfg_t  cfg_s;
    logic [7:0] cfg_q;
    logic       expire;
    logic [7:0] flags_word;
    logic [7:0] rd_mux;

    wdog_bus_decode #(
        .ADDR_W    (ADDR_W),
        .WDOG_ADDR (WDOG_ADDR),
        .FLAGS_ADDR(FLAGS_ADDR)
    ) u_dec (
        .acc_en   (acc_en),
        .acc_wr   (acc_wr),
        .acc_addr (acc_addr),
        .wr_cfg   (wr_cfg),
        .touch_cfg(touch_cfg),
        .rd_flags (rd_flags),
        .rd_any   (rd_any)
    );

    wdog_cfg_reg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_cfg(wr_cfg),
        .wdata (acc_wdata),
        .cfg_q (cfg_s)
    );

    assign cfg_q = cfg_s;

    wdog_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(touch_cfg),
        .tick   (tick_16hz),
        .period (period_ticks(cfg_s)),
        .expire (expire)
    );

    wdog_flag u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .expire   (expire),
        .touch_cfg(touch_cfg),
        .rd_flags (rd_flags),
        .steer    (cfg_s.steer),
        .flag_q   (wdog_flag),
        .irq      (irq_req)
    );

    // Purpose: assemble the flags register image and select read data.
    always_comb begin
        flags_word           = '0;
        flags_word[FLAG_BIT] = wdog_flag;
        if (acc_addr == WDOG_ADDR)       rd_mux = cfg_q;
        else if (acc_addr == FLAGS_ADDR) rd_mux = flags_word;
        else                             rd_mux = '0;
    end

    // Purpose: capture read data on a read strobe and hold it afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n)      acc_rdata <= '0;
        else if (rd_any) acc_rdata <= rd_mux;
    end

endmodule

// File: rtl/wdog_timer_chk.sv
// Module: property checker for wdog_timer, attached with bind below.
// Assumes the same address parameters as the bound instance.
module wdog_timer_chk #(
    parameter int                ADDR_W     = 4,
    parameter logic [ADDR_W-1:0] WDOG_ADDR  = 7,
    parameter logic [ADDR_W-1:0] FLAGS_ADDR = 0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_16hz,
    input logic              acc_en,
    input logic              acc_wr,
    input logic [ADDR_W-1:0] acc_addr,
    input logic [7:0]        cfg_q,
    input logic              wdog_flag,
    input logic              irq_req
);

    logic touch, rd0;
    always_comb begin
        touch = acc_en && (acc_addr == WDOG_ADDR);
        rd0   = acc_en && !acc_wr && (acc_addr == FLAGS_ADDR);
    end

    // R3: the flag only rises on an edge that sampled a tick
    p_rise_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdog_flag) |-> $past(tick_16hz));

    // R4: an access to the watchdog register never lets the flag rise next
    p_touch_no_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        touch |=> !$rose(wdog_flag));

    // R5: zero multiplier never expires
    p_zero_mult_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q[6:2] == 5'd0) |=> !$rose(wdog_flag));

    // R6: access clears the flag; otherwise it is held
    p_touch_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        touch |=> !wdog_flag);
    p_flag_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wdog_flag && !touch && !rd0) |=> wdog_flag);

    // R7: a flags read with no tick clears the flag
    p_flags_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd0 && !tick_16hz) |=> !wdog_flag);

    // R9: interrupt only with the flag, never when steered away
    p_irq_needs_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> wdog_flag);
    p_steer_blocks_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q[7] |-> !irq_req);

endmodule

bind wdog_timer wdog_timer_chk #(
    .ADDR_W    (ADDR_W),
    .WDOG_ADDR (WDOG_ADDR),
    .FLAGS_ADDR(FLAGS_ADDR)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_16hz(tick_16hz),
    .acc_en   (acc_en),
    .acc_wr   (acc_wr),
    .acc_addr (acc_addr),
    .cfg_q    (cfg_q),
    .wdog_flag(wdog_flag),
    .irq_req  (irq_req)
);

// File: tb/wdog_timer_test.sv
// Bench: directed stimulus plus a behavioural reference model compared on
// every clock. Inputs change on falling edges; outputs are sampled there.
module wdog_timer_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_16hz = 1'b0;
    logic       acc_en = 1'b0;
    logic       acc_wr = 1'b0;
    logic [3:0] acc_addr = 4'h0;
    logic [7:0] acc_wdata = 8'h00;
    logic [7:0] acc_rdata;
    logic       wdog_flag;
    logic       irq_req;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string phase = "R1";

    always #5 clk = ~clk;

    wdog_timer uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_16hz(tick_16hz),
        .acc_en   (acc_en),
        .acc_wr   (acc_wr),
        .acc_addr (acc_addr),
        .acc_wdata(acc_wdata),
        .acc_rdata(acc_rdata),
        .wdog_flag(wdog_flag),
        .irq_req  (irq_req)
    );

    // ---------------- reference model ----------------
    int m_cfg = 0, m_cnt = 0, m_rdata = 0;
    bit m_run = 0, m_wf = 0;

    function automatic int model_period(int c);
        return ((c >> 2) & 31) * (1 << (2 * (c & 3)));
    endfunction

    always @(posedge clk) begin
        bit touch, rd0, exp_now;
        if (!rst_n) begin
            m_cfg = 0; m_cnt = 0; m_rdata = 0; m_run = 0; m_wf = 0;
        end else begin
            touch   = acc_en && acc_addr == 4'h7;
            rd0     = acc_en && !acc_wr && acc_addr == 4'h0;
            exp_now = 0;
            if (acc_en && !acc_wr)
                m_rdata = (acc_addr == 4'h7) ? m_cfg :
                          (acc_addr == 4'h0) ? (m_wf ? 8'h80 : 0) : 0;
            if (touch) begin
                if (acc_wr) m_cfg = int'(acc_wdata);
                m_cnt = 0;
                m_run = 1;
            end else if (tick_16hz && m_run && model_period(m_cfg) != 0) begin
                m_cnt++;
                if (m_cnt == model_period(m_cfg)) begin
                    exp_now = 1; m_run = 0; m_cnt = 0;
                end
            end
            if (exp_now) m_wf = 1;
            else if (touch || rd0) m_wf = 0;
        end
    end

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at cycle %0d", req, act, exp, cycles);
        end
    endtask

    // Purpose: compare all outputs with the model every cycle.
    always @(negedge clk) begin
        if (rst_n) begin
            check({phase, " model flag"}, int'(wdog_flag), int'(m_wf));
            check({phase, " model irq R9"}, int'(irq_req), int'(m_wf && !m_cfg[7]));
            check({phase, " model rdata R10"}, int'(acc_rdata), m_rdata);
        end
    end

    // Watchdog: an expired run is one failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles == 150000) begin
            checks++; errors++;
            $display("FAIL %s: watchdog expired actual=%0d expected<150000", phase, cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_tick();
        tick_16hz = 1'b1;
        @(negedge clk);
        tick_16hz = 1'b0;
        idle(3);
    endtask

    task automatic access(bit wr, logic [3:0] addr, logic [7:0] data, bit with_tick,
                          output logic [7:0] rd);
        acc_en = 1'b1; acc_wr = wr; acc_addr = addr; acc_wdata = data;
        tick_16hz = with_tick;
        @(negedge clk);
        acc_en = 1'b0; acc_wr = 1'b0; tick_16hz = 1'b0;
        rd = acc_rdata;
        idle(1);
    endtask

    task automatic ticks_to_flag(int limit, output int n);
        n = -1;
        for (int i = 1; i <= limit; i++) begin
            tick_16hz = 1'b1;
            @(negedge clk);
            tick_16hz = 1'b0;
            if (wdog_flag) begin n = i; break; end
            idle(3);
        end
        idle(3);
    endtask

    initial begin
        logic [7:0] rd;
        int n;

        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1: reset state
        phase = "R1";
        check("R1 flag after reset", int'(wdog_flag), 0);
        check("R1 irq after reset", int'(irq_req), 0);
        access(0, 4'h7, 8'h00, 0, rd);
        check("R1 config reads 00h", int'(rd), 8'h00);
        for (int i = 0; i < 30; i++) pulse_tick();
        check("R1 idle after reset", int'(wdog_flag), 0);

        // R2/R3: 05h -> 1 x 4 ticks
        phase = "R3";
        access(1, 4'h7, 8'h05, 0, rd);
        ticks_to_flag(100, n);
        check("R3 ticks to flag for 05h", n, 4);
        check("R9 irq follows flag", int'(irq_req), 1);

        // R8: flag cleared via 0h, no new timeout without a restart
        phase = "R8";
        access(0, 4'h0, 8'h00, 0, rd);
        check("R7 flags read returns 80h", int'(rd), 8'h80);
        check("R7 flag cleared", int'(wdog_flag), 0);
        for (int i = 0; i < 20; i++) pulse_tick();
        check("R8 counter halted", int'(wdog_flag), 0);

        // R2: resolution 00 -> 3 x 1
        phase = "R2";
        access(1, 4'h7, 8'h0C, 0, rd);
        ticks_to_flag(100, n);
        check("R2 ticks to flag for 0Ch", n, 3);

        // R6: access to 7h clears the flag
        phase = "R6";
        access(0, 4'h7, 8'h00, 0, rd);
        check("R6 config read clears flag", int'(wdog_flag), 0);
        check("R10 config read data", int'(rd), 8'h0C);

        // R4: restart part way through 0Eh -> 3 x 16
        phase = "R4";
        access(1, 4'h7, 8'h0E, 0, rd);
        for (int i = 0; i < 40; i++) pulse_tick();
        access(0, 4'h7, 8'h00, 0, rd);
        ticks_to_flag(100, n);
        check("R4 restart by read, ticks to flag", n, 48);
        check("R10 rdata held after read", int'(acc_rdata), 8'h0E);

        // R11: stray writes ignored while the flag is set
        phase = "R11";
        access(1, 4'h3, 8'hFF, 0, rd);
        access(1, 4'h0, 8'h00, 0, rd);
        check("R11 flag kept after stray writes", int'(wdog_flag), 1);
        access(0, 4'h5, 8'h00, 0, rd);
        check("R10 unused address reads 00h", int'(rd), 8'h00);
        check("R11 flag kept after unused read", int'(wdog_flag), 1);
        access(0, 4'h7, 8'h00, 0, rd);
        check("R11 config unchanged", int'(rd), 8'h0E);

        // R4: access on the same edge as the expiring tick
        phase = "R4";
        access(1, 4'h7, 8'h05, 0, rd);
        for (int i = 0; i < 3; i++) pulse_tick();
        access(1, 4'h7, 8'h05, 1, rd);
        check("R4 coinciding tick not counted", int'(wdog_flag), 0);
        ticks_to_flag(100, n);
        check("R4 full period after coinciding restart", n, 4);

        // R7: flags read on the same edge as expiry
        phase = "R7";
        access(1, 4'h7, 8'h05, 0, rd);
        for (int i = 0; i < 3; i++) pulse_tick();
        access(0, 4'h0, 8'h00, 1, rd);
        check("R7 read returns pre-expiry flag", int'(rd), 8'h00);
        check("R7 expiry wins over clear", int'(wdog_flag), 1);

        // R9: steering bit set, 86h -> 1 x 16
        phase = "R9";
        access(1, 4'h7, 8'h86, 0, rd);
        ticks_to_flag(100, n);
        check("R9 flag with steer set", n, 16);
        check("R9 irq low with steer set", int'(irq_req), 0);

        // R5: zero multiplier
        phase = "R5";
        access(1, 4'h7, 8'h00, 0, rd);
        for (int i = 0; i < 200; i++) pulse_tick();
        check("R5 00h never expires", int'(wdog_flag), 0);
        access(1, 4'h7, 8'h03, 0, rd);
        for (int i = 0; i < 200; i++) pulse_tick();
        check("R5 03h never expires", int'(wdog_flag), 0);

        // R2: largest timeout 7Fh -> 31 x 64
        phase = "R2";
        access(1, 4'h7, 8'h7F, 0, rd);
        ticks_to_flag(3000, n);
        check("R2 ticks to flag for 7Fh", n, 1984);

        idle(4);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule